// File: doc/BRIEF.md
# Integer Execute ALU

This block is the combinational integer execute stage of a small 32-bit RISC core. Each cycle it takes an operation code, two operands, the processor's current carry and condition flag, and an option bit that lets arithmetic results update the condition flag. It returns the result word, the next carry, the next condition flag, a write-enable for the destination register and an illegal-operation strobe. Register file access, overflow traps and pipeline control are left to the surrounding core.

The unit covers addition with and without carry-in, subtraction, multiplication, signed and unsigned division, the bitwise operations, three shift kinds, the upper-half immediate load, byte and halfword extension, conditional selection, lowest-set-bit search and ten comparisons that only touch the condition flag. The carry comes from an unsigned wrap test against the second operand. A zero divisor produces no writeback and raises the illegal strobe.

Top module: `int_alu_core`

## Requirements
- R1: The 5-bit operation code is: 0 add, 1 add-with-carry, 2 subtract, 3 multiply, 4 signed divide, 5 unsigned divide, 6 AND, 7 OR, 8 XOR, 9 shift left, 10 logical shift right, 11 arithmetic shift right, 12 move-high, 13 sign-extend byte, 14 zero-extend byte, 15 sign-extend halfword, 16 zero-extend halfword, 17 conditional move, 18 find-first-one, 19 flag-if-equal, 20 flag-if-not-equal, 21 signed greater-than, 22 signed greater-or-equal, 23 signed less-than, 24 signed less-or-equal, 25 unsigned greater-than, 26 unsigned greater-or-equal, 27 unsigned less-than, 28 unsigned less-or-equal. Codes 29 to 31 raise the illegal strobe, drive write-enable low and the result to zero, and leave carry and flag unchanged.
- R2: Add returns the 32-bit sum a+b; add-with-carry adds one more when carry-in is set. For both, next carry is 1 exactly when the unsigned sum is smaller than the unsigned second operand (b), else 0.
- R3: With the option bit set, add, add-with-carry and AND set the next flag when their result is zero and clear it otherwise; with the option bit clear, and for every other non-comparison operation, the next flag equals the incoming flag. Every operation other than add and add-with-carry passes the incoming carry through.
- R4: Subtract returns a-b and multiply returns the low 32 bits of a*b.
- R5: Unsigned divide returns floor(a/b); signed divide truncates toward zero, and dividing the most negative value by -1 returns the dividend.
- R6: A divide with b equal to zero drives write-enable low, the illegal strobe high and the result to zero, with carry and flag unchanged.
- R7: AND, OR and XOR are bitwise; shifts take their amount from b[4:0] only; arithmetic right shift fills with a[31].
- R8: Move-high returns b[15:0] in bits 31:16 with bits 15:0 zero.
- R9: The extension operations sign- or zero-extend a[7:0] or a[15:0] to 32 bits.
- R10: Conditional move returns a when the incoming flag is 1 and b when it is 0.
- R11: Find-first-one returns the 1-based index of the lowest set bit of a (1 for bit 0, 32 for bit 31) and 0 when a is zero.
- R12: A comparison sets the next flag when its relation between a and b holds, clears it otherwise, drives write-enable low and the result to zero, and passes the carry through.
- R13: Every assigned non-comparison operation that is not a zero-divisor divide drives write-enable high and the illegal strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand or immediate |
| carry_i | input | 1 | Current carry bit |
| flag_i | input | 1 | Current condition flag |
| arith_flag_en_i | input | 1 | Lets add, add-with-carry and AND update the flag |
| result_o | output | 32 | Result word |
| carry_o | output | 1 | Next carry bit |
| flag_o | output | 1 | Next condition flag |
| wr_en_o | output | 1 | Destination write-enable |
| illegal_o | output | 1 | Illegal-operation strobe |

## Verification
Assertions watch, on every evaluation, that a plain add's carry agrees with a wrap test against the first operand, that the lowest-set-bit index points at a set bit with only zeros below it, that an unsigned quotient reconstructs the dividend, that comparisons and illegal cases never write and never disturb the carry, and that arithmetic right shifts keep the sign. The carry quirk of add-with-carry when the first operand wraps, the signed divide overflow corner, the option bit's effect on the flag and the exact values of all operations across mixed random and edge operands are only shown by the bench's scenarios against its own model.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADD   = 5'd0,
      OP_ADDC  = 5'd1,
      OP_SUB   = 5'd2,
      OP_MUL   = 5'd3,
      OP_DIVS  = 5'd4,
      OP_DIVU  = 5'd5,
      OP_AND   = 5'd6,
      OP_OR    = 5'd7,
      OP_XOR   = 5'd8,
      OP_SLL   = 5'd9,
      OP_SRL   = 5'd10,
      OP_SRA   = 5'd11,
      OP_MOVHI = 5'd12,
      OP_EXTBS = 5'd13,
      OP_EXTBZ = 5'd14,
      OP_EXTHS = 5'd15,
      OP_EXTHZ = 5'd16,
      OP_CMOV  = 5'd17,
      OP_FF1   = 5'd18,
      OP_CEQ   = 5'd19,
      OP_CNE   = 5'd20,
      OP_CGTS  = 5'd21,
      OP_CGES  = 5'd22,
      OP_CLTS  = 5'd23,
      OP_CLES  = 5'd24,
      OP_CGTU  = 5'd25,
      OP_CGEU  = 5'd26,
      OP_CLTU  = 5'd27,
      OP_CLEU  = 5'd28
   } alu_op_e;

   localparam logic [OP_W-1:0] OP_LAST = OP_CLEU;

   function automatic logic op_is_compare(input logic [OP_W-1:0] op);
      return (op >= OP_CEQ) && (op <= OP_CLEU);
   endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
   import int_alu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [OP_W-1:0] op_i,
   input  logic [W-1:0]    a_i,
   input  logic [W-1:0]    b_i,
   input  logic            carry_i,
   output logic [W-1:0]    sum_o,
   output logic            carry_o
);

   logic cin;

   assign cin = (op_i == OP_ADDC) && carry_i;

   always_comb begin
      sum_o   = '0;
      carry_o = carry_i;
      case (op_i)
         OP_ADD, OP_ADDC: begin
            sum_o   = a_i + b_i + W'(cin);
            carry_o = (sum_o < b_i);
         end
         OP_SUB: sum_o = a_i - b_i;
         default: sum_o = '0;
      endcase
   end

   // without carry-in, wrapping below b and below a are the same event
   always_comb begin
      if (op_i == OP_ADD) begin
         p_add_wrap_r2: assert (carry_o == (sum_o < a_i))
            else $error("add carry disagrees with wrap against first operand");
      end
   end

endmodule

// File: rtl/alu_ff1.sv
module alu_ff1 #(
   parameter int W    = 32,
   parameter bit TREE = 1'b1
) (
   input  logic [W-1:0] val_i,
   output logic [W-1:0] pos_o
);

   localparam int IDX_W = $clog2(W);

   generate
      if (TREE) begin : g_tree
         logic [W-1:0]     lowest;
         logic [IDX_W-1:0] idx;

         assign lowest = val_i & (~val_i + W'(1));

         for (genvar k = 0; k < IDX_W; k++) begin : g_bit
            logic [W-1:0] mask;
            for (genvar j = 0; j < W; j++) begin : g_mask
               assign mask[j] = (((j >> k) % 2) == 1);
            end
            assign idx[k] = |(lowest & mask);
         end

         assign pos_o = (val_i == '0) ? '0 : (W'(idx) + W'(1));
      end else begin : g_scan
         always_comb begin
            pos_o = '0;
            for (int i = W - 1; i >= 0; i--) begin
               if (val_i[i]) pos_o = W'(i + 1);
            end
         end
      end
   endgenerate

   always_comb begin
      if (val_i == '0) begin
         p_ff1_zero_r11: assert (pos_o == '0)
            else $error("lowest-bit index nonzero for zero operand");
      end else begin
         p_ff1_hit_r11: assert ((pos_o != '0) && (pos_o <= W'(W))
                                && val_i[IDX_W'(pos_o - W'(1))]
                                && ((val_i & ((W'(1) << (pos_o - W'(1))) - W'(1))) == '0))
            else $error("lowest-bit index does not point at the lowest set bit");
      end
   end

endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
   import int_alu_pkg::*;
#(
   parameter int W        = 32,
   parameter bit FF1_TREE = 1'b1
) (
   input  logic [OP_W-1:0] op_i,
   input  logic [W-1:0]    a_i,
   input  logic [W-1:0]    b_i,
   input  logic            flag_i,
   output logic [W-1:0]    res_o
);

   localparam int SH_W  = $clog2(W);
   localparam int HALF  = W / 2;

   logic [SH_W-1:0] shamt;
   logic [W-1:0]    ff1_pos;
   logic [W-1:0]    sra_val;

   assign shamt   = b_i[SH_W-1:0];
   assign sra_val = $unsigned($signed(a_i) >>> shamt);

   alu_ff1 #(.W(W), .TREE(FF1_TREE)) u_ff1 (
      .val_i (a_i),
      .pos_o (ff1_pos)
   );

   always_comb begin
      case (op_i)
         OP_AND:   res_o = a_i & b_i;
         OP_OR:    res_o = a_i | b_i;
         OP_XOR:   res_o = a_i ^ b_i;
         OP_SLL:   res_o = a_i << shamt;
         OP_SRL:   res_o = a_i >> shamt;
         OP_SRA:   res_o = sra_val;
         OP_MOVHI: res_o = {b_i[HALF-1:0], {HALF{1'b0}}};
         OP_EXTBS: res_o = {{(W-8){a_i[7]}}, a_i[7:0]};
         OP_EXTBZ: res_o = {{(W-8){1'b0}}, a_i[7:0]};
         OP_EXTHS: res_o = {{(W-16){a_i[15]}}, a_i[15:0]};
         OP_EXTHZ: res_o = {{(W-16){1'b0}}, a_i[15:0]};
         OP_CMOV:  res_o = flag_i ? a_i : b_i;
         OP_FF1:   res_o = ff1_pos;
         default:  res_o = '0;
      endcase
   end

   always_comb begin
      if (op_i == OP_SRA) begin
         p_sra_sign_r7: assert (res_o[W-1] == a_i[W-1])
            else $error("arithmetic shift lost the sign bit");
      end
      if (op_i == OP_MOVHI) begin
         p_movhi_low_r8: assert (res_o[HALF-1:0] == '0)
            else $error("move-high left bits in the lower half");
      end
   end

endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv
   import int_alu_pkg::*;
#(
   parameter int W      = 32,
   parameter bit DIV_EN = 1'b1
) (
   input  logic [OP_W-1:0] op_i,
   input  logic [W-1:0]    a_i,
   input  logic [W-1:0]    b_i,
   output logic [W-1:0]    res_o,
   output logic            bad_o
);

   logic [W-1:0] prod;
   logic [W-1:0] quo_u;
   logic [W-1:0] quo_s;
   logic         div_ok;

   assign prod = a_i * b_i;

   generate
      if (DIV_EN) begin : g_div
         logic         neg_a, neg_b;
         logic [W-1:0] mag_a, mag_b, safe_b, safe_mb, mag_q;

         assign neg_a   = a_i[W-1];
         assign neg_b   = b_i[W-1];
         assign mag_a   = neg_a ? (~a_i + W'(1)) : a_i;
         assign mag_b   = neg_b ? (~b_i + W'(1)) : b_i;
         assign safe_b  = (b_i == '0) ? W'(1) : b_i;
         assign safe_mb = (mag_b == '0) ? W'(1) : mag_b;
         assign quo_u   = a_i / safe_b;
         assign mag_q   = mag_a / safe_mb;
         assign quo_s   = (neg_a ^ neg_b) ? (~mag_q + W'(1)) : mag_q;
         assign div_ok  = (b_i != '0);

         always_comb begin
            if ((op_i == OP_DIVU) && (b_i != '0)) begin
               p_divu_recon_r5: assert (((quo_u * b_i) <= a_i)
                                        && ((a_i - quo_u * b_i) < b_i))
                  else $error("unsigned quotient does not reconstruct dividend");
            end
         end
      end else begin : g_nodiv
         assign quo_u  = '0;
         assign quo_s  = '0;
         assign div_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      res_o = '0;
      bad_o = 1'b0;
      case (op_i)
         OP_MUL:  res_o = prod;
         OP_DIVS: if (div_ok) res_o = quo_s; else bad_o = 1'b1;
         OP_DIVU: if (div_ok) res_o = quo_u; else bad_o = 1'b1;
         default: res_o = '0;
      endcase
   end

   always_comb begin
      if (((op_i == OP_DIVS) || (op_i == OP_DIVU)) && (b_i == '0)) begin
         p_divzero_flag_r6: assert (bad_o)
            else $error("zero divisor not reported");
      end
   end

endmodule

// File: rtl/alu_cmp.sv
module alu_cmp
   import int_alu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [OP_W-1:0] op_i,
   input  logic [W-1:0]    a_i,
   input  logic [W-1:0]    b_i,
   output logic            hit_o
);

   logic eq, ltu, lts;

   assign eq  = (a_i == b_i);
   assign ltu = (a_i < b_i);
   assign lts = ($signed(a_i) < $signed(b_i));

   always_comb begin
      case (op_i)
         OP_CEQ:  hit_o = eq;
         OP_CNE:  hit_o = !eq;
         OP_CGTS: hit_o = !lts && !eq;
         OP_CGES: hit_o = !lts;
         OP_CLTS: hit_o = lts;
         OP_CLES: hit_o = lts || eq;
         OP_CGTU: hit_o = !ltu && !eq;
         OP_CGEU: hit_o = !ltu;
         OP_CLTU: hit_o = ltu;
         OP_CLEU: hit_o = ltu || eq;
         default: hit_o = 1'b0;
      endcase
   end

   logic [W:0] diff_ext;
   assign diff_ext = {1'b0, a_i} - {1'b0, b_i};

   always_comb begin
      if (op_i == OP_CLTU) begin
         p_cmp_borrow_r12: assert (hit_o == diff_ext[W])
            else $error("unsigned less-than disagrees with borrow");
      end
      if (op_i == OP_CEQ) begin
         p_cmp_eq_r12: assert (hit_o == ((a_i ^ b_i) == '0))
            else $error("equality flag disagrees with xor test");
      end
   end

endmodule

// File: rtl/int_alu_core.sv
module int_alu_core
   import int_alu_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit DIV_EN   = 1'b1,
   parameter bit FF1_TREE = 1'b1
) (
   input  logic [OP_W-1:0]   op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              carry_i,
   input  logic              flag_i,
   input  logic              arith_flag_en_i,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o,
   output logic              flag_o,
   output logic              wr_en_o,
   output logic              illegal_o
);

   generate
      if ((DATA_W < 16) || ((DATA_W & (DATA_W - 1)) != 0)) begin : g_bad_width
         $error("DATA_W must be a power of two of at least 16");
      end
   endgenerate

   logic [DATA_W-1:0] as_sum, bit_res, md_res;
   logic              as_carry, md_bad, cmp_hit;

   alu_addsub #(.W(DATA_W)) u_addsub (
      .op_i    (op_i),
      .a_i     (a_i),
      .b_i     (b_i),
      .carry_i (carry_i),
      .sum_o   (as_sum),
      .carry_o (as_carry)
   );

   alu_bitops #(.W(DATA_W), .FF1_TREE(FF1_TREE)) u_bitops (
      .op_i   (op_i),
      .a_i    (a_i),
      .b_i    (b_i),
      .flag_i (flag_i),
      .res_o  (bit_res)
   );

   alu_muldiv #(.W(DATA_W), .DIV_EN(DIV_EN)) u_muldiv (
      .op_i  (op_i),
      .a_i   (a_i),
      .b_i   (b_i),
      .res_o (md_res),
      .bad_o (md_bad)
   );

   alu_cmp #(.W(DATA_W)) u_cmp (
      .op_i  (op_i),
      .a_i   (a_i),
      .b_i   (b_i),
      .hit_o (cmp_hit)
   );

   always_comb begin
      result_o  = '0;
      carry_o   = carry_i;
      flag_o    = flag_i;
      wr_en_o   = 1'b1;
      illegal_o = 1'b0;
      case (op_i)
         OP_ADD, OP_ADDC: begin
            result_o = as_sum;
            carry_o  = as_carry;
            if (arith_flag_en_i) flag_o = (as_sum == '0);
         end
         OP_SUB: result_o = as_sum;
         OP_MUL, OP_DIVS, OP_DIVU: begin
            if (md_bad) begin
               illegal_o = 1'b1;
               wr_en_o   = 1'b0;
            end else begin
               result_o = md_res;
            end
         end
         OP_AND: begin
            result_o = bit_res;
            if (arith_flag_en_i) flag_o = (bit_res == '0);
         end
         OP_OR, OP_XOR, OP_SLL, OP_SRL, OP_SRA, OP_MOVHI,
         OP_EXTBS, OP_EXTBZ, OP_EXTHS, OP_EXTHZ, OP_CMOV, OP_FF1:
            result_o = bit_res;
         OP_CEQ, OP_CNE, OP_CGTS, OP_CGES, OP_CLTS,
         OP_CLES, OP_CGTU, OP_CGEU, OP_CLTU, OP_CLEU: begin
            flag_o  = cmp_hit;
            wr_en_o = 1'b0;
         end
         default: begin
            illegal_o = 1'b1;
            wr_en_o   = 1'b0;
         end
      endcase
   end

   always_comb begin
      if (illegal_o) begin
         p_illegal_quiet_r6: assert (!wr_en_o && (result_o == '0)
                                     && (carry_o == carry_i) && (flag_o == flag_i))
            else $error("illegal case wrote or disturbed state");
      end
      if (op_is_compare(op_i)) begin
         p_cmp_nowrite_r12: assert (!wr_en_o && !illegal_o && (carry_o == carry_i)
                                    && (result_o == '0))
            else $error("comparison wrote a result or carry");
      end
      if (op_i > OP_LAST) begin
         p_unassigned_r1: assert (illegal_o)
            else $error("unassigned code not flagged illegal");
      end
      if (!op_is_compare(op_i) && (op_i <= OP_LAST)
          && !(((op_i == OP_DIVS) || (op_i == OP_DIVU)) && (b_i == '0))) begin
         p_write_on_r13: assert (wr_en_o && !illegal_o)
            else $error("valid operation did not write");
      end
   end

endmodule

// File: tb/tb_int_alu_core.sv
module tb_int_alu_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  op;
   logic [31:0] a, b;
   logic        cin, fin, fen;
   logic [31:0] res;
   logic        cout, fout, we, ill;

   int n_run  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   int_alu_core dut (
      .op_i            (op),
      .a_i             (a),
      .b_i             (b),
      .carry_i         (cin),
      .flag_i          (fin),
      .arith_flag_en_i (fen),
      .result_o        (res),
      .carry_o         (cout),
      .flag_o          (fout),
      .wr_en_o         (we),
      .illegal_o       (ill)
   );

   typedef struct packed {
      logic [31:0] r;
      logic        c, f, w, x;
   } exp_t;

   function automatic logic slt(input logic [31:0] x, input logic [31:0] y);
      return (x ^ 32'h8000_0000) < (y ^ 32'h8000_0000);
   endfunction

   function automatic exp_t model(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y,
                                  input logic c, input logic f, input logic en);
      exp_t e;
      logic [31:0] mx, my, q;
      logic [4:0]  s;
      s = y[4:0];
      e.r = 32'h0; e.c = c; e.f = f; e.w = 1'b1; e.x = 1'b0;
      case (o)
         5'd0: begin e.r = x + y; e.c = (e.r < y); if (en) e.f = (e.r == 0); end
         5'd1: begin e.r = x + y + {31'b0, c}; e.c = (e.r < y); if (en) e.f = (e.r == 0); end
         5'd2: e.r = x - y;
         5'd3: e.r = x * y;
         5'd4: if (y == 0) e.x = 1'b1;
               else begin
                  mx = x[31] ? (32'h0 - x) : x;
                  my = y[31] ? (32'h0 - y) : y;
                  q  = mx / my;
                  e.r = (x[31] != y[31]) ? (32'h0 - q) : q;
               end
         5'd5: if (y == 0) e.x = 1'b1; else e.r = x / y;
         5'd6: begin e.r = x & y; if (en) e.f = (e.r == 0); end
         5'd7: e.r = x | y;
         5'd8: e.r = x ^ y;
         5'd9: e.r = x << s;
         5'd10: e.r = x >> s;
         5'd11: e.r = (x >> s) | (x[31] ? ~(32'hFFFF_FFFF >> s) : 32'h0);
         5'd12: e.r = {y[15:0], 16'h0};
         5'd13: e.r = {{24{x[7]}}, x[7:0]};
         5'd14: e.r = {24'h0, x[7:0]};
         5'd15: e.r = {{16{x[15]}}, x[15:0]};
         5'd16: e.r = {16'h0, x[15:0]};
         5'd17: e.r = f ? x : y;
         5'd18: begin
            for (int i = 0; i < 32; i++) begin
               if (x[i]) begin e.r = i + 1; break; end
            end
         end
         5'd19: begin e.f = (x == y);               e.w = 1'b0; end
         5'd20: begin e.f = (x != y);               e.w = 1'b0; end
         5'd21: begin e.f = slt(y, x);              e.w = 1'b0; end
         5'd22: begin e.f = !slt(x, y);             e.w = 1'b0; end
         5'd23: begin e.f = slt(x, y);              e.w = 1'b0; end
         5'd24: begin e.f = !slt(y, x);             e.w = 1'b0; end
         5'd25: begin e.f = (x > y);                e.w = 1'b0; end
         5'd26: begin e.f = (x >= y);               e.w = 1'b0; end
         5'd27: begin e.f = (x < y);                e.w = 1'b0; end
         5'd28: begin e.f = (x <= y);               e.w = 1'b0; end
         default: e.x = 1'b1;
      endcase
      if (e.x) begin e.r = 32'h0; e.w = 1'b0; e.c = c; e.f = f; end
      return e;
   endfunction

   function automatic string tag_of(input logic [4:0] o, input logic [31:0] y);
      if (o <= 5'd1) return "R2";
      if (o <= 5'd3) return "R4";
      if (o <= 5'd5) return (y == 0) ? "R6" : "R5";
      if (o <= 5'd11) return "R7";
      if (o == 5'd12) return "R8";
      if (o <= 5'd16) return "R9";
      if (o == 5'd17) return "R10";
      if (o == 5'd18) return "R11";
      if (o <= 5'd28) return "R12";
      return "R1";
   endfunction

   task automatic run(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y,
                      input logic c, input logic f, input logic en, input string tag);
      exp_t e;
      @(negedge clk);
      op = o; a = x; b = y; cin = c; fin = f; fen = en;
      #5;
      e = model(o, x, y, c, f, en);
      n_run++;
      if ({res, cout, fout, we, ill} !== e) begin
         n_fail++;
         $display("FAIL %s op=%0d a=%h b=%h c=%b f=%b en=%b: got r=%h c=%b f=%b we=%b ill=%b, exp r=%h c=%b f=%b we=%b ill=%b",
                  tag, o, x, y, c, f, en, res, cout, fout, we, ill, e.r, e.c, e.f, e.w, e.x);
      end
   endtask

   function automatic logic [31:0] pick();
      case ($urandom % 6)
         0: return 32'($urandom_range(40));
         1: return 32'hFFFF_FFFF - 32'($urandom_range(40));
         2: return 32'h8000_0000 + 32'($urandom_range(8)) - 32'd4;
         3: return 32'h0;
         default: return $urandom;
      endcase
   endfunction

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] seed_ret;
      seed_ret = $urandom(32'd4242);
      op = 5'd0; a = 0; b = 0; cin = 0; fin = 0; fen = 0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // quiescent start: add of zeros
      run(5'd0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, "R13");
      // R1 unassigned codes
      run(5'd29, 32'h1234, 32'h5678, 1'b1, 1'b0, 1'b1, "R1");
      run(5'd31, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b1, 1'b0, "R1");
      // R2 carry corners, including wrap of the first operand with carry-in
      run(5'd0, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0, 1'b0, "R2");
      run(5'd1, 32'h0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, "R2");
      run(5'd1, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0, 1'b0, "R2");
      run(5'd1, 32'h7, 32'h8, 1'b1, 1'b1, 1'b0, "R2");
      // R3 flag option on and off
      run(5'd0, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0, 1'b1, "R3");
      run(5'd0, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b1, 1'b0, "R3");
      run(5'd6, 32'hF0F0_0000, 32'h0F0F_FFFF, 1'b1, 1'b0, 1'b1, "R3");
      run(5'd7, 32'h0, 32'h0, 1'b1, 1'b1, 1'b1, "R3");
      run(5'd2, 32'h5, 32'h5, 1'b1, 1'b0, 1'b1, "R3");
      // R4
      run(5'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, "R4");
      // R5 signed corners
      run(5'd4, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, "R5");
      run(5'd4, 32'hFFFF_FFF9, 32'h2, 1'b0, 1'b0, 1'b0, "R5");
      run(5'd5, 32'hFFFF_FFF9, 32'h2, 1'b0, 1'b0, 1'b0, "R5");
      // R6 zero divisor
      run(5'd4, 32'h1234_5678, 32'h0, 1'b1, 1'b1, 1'b1, "R6");
      run(5'd5, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, "R6");
      // R7 shift amount masking and sign fill
      run(5'd11, 32'h8000_0000, 32'd31, 1'b0, 1'b0, 1'b0, "R7");
      run(5'd9, 32'h1, 32'd33, 1'b0, 1'b0, 1'b0, "R7");
      run(5'd10, 32'h8000_0000, 32'hFFFF_FFE4, 1'b0, 1'b0, 1'b0, "R7");
      // R8 to R11
      run(5'd12, 32'hFFFF_FFFF, 32'hABCD_1234, 1'b0, 1'b0, 1'b0, "R8");
      run(5'd13, 32'h0000_0080, 32'h0, 1'b0, 1'b0, 1'b0, "R9");
      run(5'd15, 32'hFFFF_7FFF, 32'h0, 1'b0, 1'b0, 1'b0, "R9");
      run(5'd17, 32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 1'b1, 1'b0, "R10");
      run(5'd17, 32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 1'b0, 1'b0, "R10");
      run(5'd18, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, "R11");
      run(5'd18, 32'h8000_0000, 32'h0, 1'b0, 1'b0, 1'b0, "R11");
      run(5'd18, 32'h0000_0001, 32'h0, 1'b0, 1'b0, 1'b0, "R11");
      // R12 signed against unsigned ordering
      run(5'd23, 32'h8000_0000, 32'h1, 1'b1, 1'b0, 1'b0, "R12");
      run(5'd27, 32'h8000_0000, 32'h1, 1'b1, 1'b1, 1'b0, "R12");
      run(5'd22, 32'h5, 32'h5, 1'b0, 1'b0, 1'b0, "R12");
      run(5'd25, 32'h5, 32'h5, 1'b0, 1'b1, 1'b0, "R12");

      for (int k = 0; k < 5000; k++) begin
         logic [4:0]  o;
         logic [31:0] x, y;
         o = 5'($urandom_range(31));
         x = pick();
         y = pick();
         run(o, x, y, 1'($urandom), 1'($urandom), 1'($urandom), tag_of(o, y));
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule